// File: doc/BRIEF.md
# SPI Slave Boot Loader

The block takes a boot image from an external SPI master, one byte at a time, and places it into on-chip memory through a simple write port. The image is a chain of blocks. Each block opens with a ten-byte header that names where the payload goes, how many bytes it holds and a set of flags. Bytes after the header go to consecutive memory locations. A flagged block fills its range with zeros and takes no payload from the link. A block with no bytes is passed over.

While the loader cannot take another byte it raises a host-wait line, and the master must pause until the line drops. Which of 64 general-purpose lines carries this wait is chosen by a field in each header. When the block marked final has been written, the loader issues a one-cycle start pulse together with the base address of instruction memory. A software reset either restarts the header parse or, when the bypass configuration bit is set, skips loading and issues the start pulse at once.

Top module: `spi_boot_loader`

## Requirements
- R1: SPI mode 0: MOSI is sampled on each rising SCK edge while chip select is low, MSB first, and every eight bits form one byte; raising chip select discards a partly received byte.
- R2: Header bytes are little-endian: bytes 0 to 3 form the 32-bit destination address, bytes 4 to 7 the 32-bit byte count, bytes 8 and 9 the 16-bit flag word.
- R3: Each payload byte produces one write at the header address plus its index; mem_we, mem_addr and mem_wdata hold steady until mem_ready is high.
- R4: Any number of blocks load in the order received, each starting with a fresh header.
- R5: When the last write of a block with flag bit 15 set is accepted, start_pulse is high for exactly one cycle; start_addr always equals IMEM_BASE, and no write occurs while start_pulse is high.
- R6: A block with flag bit 0 set writes count zero bytes from its address, takes no payload byte from SPI, and keeps host-wait high until its last write is accepted.
- R7: A block with count zero and flag bit 15 clear writes nothing; the next SPI byte is byte 0 of the following header.
- R8: Host-wait is high in every cycle where mem_we is high and mem_ready is low, and for the one decode cycle after each tenth header byte.
- R9: Flag bits [10:5] select which bit of gpio_wait carries host-wait; every other bit stays low.
- R10: A sw_reset pulse with cfg_bypass high gives start_pulse in the next cycle, drops any write, and loads nothing more.
- R11: A sw_reset pulse with cfg_bypass low restarts parsing at header byte 0, discarding any partial header.
- R12: After reset, gpio_wait, mem_we and start_pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_reset | input | 1 | Software reset event, one cycle |
| cfg_bypass | input | 1 | Skip loading on software reset |
| spi_sck | input | 1 | SPI clock from the master |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from the master |
| gpio_wait | output | 64 | Host-wait, on the line chosen by the header |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| start_pulse | output | 1 | Begin execution, one cycle |
| start_addr | output | 32 | Execution start address |

## Verification
The acceptance of the last payload write and the start pulse sit on adjacent cycles, and a stalled memory port stretches the gap between the final byte arriving and that acceptance. The bench holds mem_ready low on three cycles out of four during the later blocks, so the final write of the last block waits behind a stall. A reference queue of expected writes is compared at every accepted write, and a start pulse counts as correct only if the queue is already empty and a final block or bypass was expected; the wait line is judged in the same cycles against the stall.

// File: rtl/spi_boot_loader.sv
module spi_boot_loader #(
  parameter logic [31:0] IMEM_BASE = 32'h0000_8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_reset,
  input  logic        cfg_bypass,
  input  logic        spi_sck,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic [63:0] gpio_wait,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_ready,
  output logic        start_pulse,
  output logic [31:0] start_addr
);
  localparam int PIN_W = 6;
  localparam int HDR_LAST = 9;

  typedef enum logic [2:0] {S_HDR, S_DEC, S_PAY, S_FILL, S_DONE} st_t;

  logic [2:0] sck_s, cs_s;
  logic [1:0] mosi_s;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic [7:0] rx_byte;
  logic       byte_vld;

  st_t         st;
  logic [3:0]  hcnt;
  logic [31:0] cnt_q;
  logic        fill_q, final_q;
  logic [2:0]  pin_lo, pin_hi;
  logic [PIN_W-1:0] pin_q;

  wire sck_rise = sck_s[1] & ~sck_s[2];
  wire accept   = mem_we & mem_ready;
  wire busy     = (st == S_DEC) | (st == S_FILL) | (mem_we & ~mem_ready);
  wire [PIN_W-1:0] pin = (st == S_DEC) ? {pin_hi, pin_lo} : pin_q;

  assign gpio_wait  = busy ? (64'd1 << pin) : 64'd0;
  assign start_addr = IMEM_BASE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sck_s  <= {sck_s[1:0], spi_sck};
      cs_s   <= {cs_s[1:0], spi_cs_n};
      mosi_s <= {mosi_s[0], spi_mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      rx_byte  <= '0;
      byte_vld <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (cs_s[1] || sw_reset) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        shreg   <= {shreg[5:0], mosi_s[1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          rx_byte  <= {shreg, mosi_s[1]};
          byte_vld <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_HDR;
      hcnt        <= '0;
      cnt_q       <= '0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      mem_we      <= 1'b0;
      fill_q      <= 1'b0;
      final_q     <= 1'b0;
      pin_lo      <= '0;
      pin_hi      <= '0;
      pin_q       <= '0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      if (sw_reset) begin
        mem_we <= 1'b0;
        hcnt   <= '0;
        if (cfg_bypass) begin
          st          <= S_DONE;
          start_pulse <= 1'b1;
        end else begin
          st <= S_HDR;
        end
      end else begin
        case (st)
          S_HDR: if (byte_vld) begin
            if (hcnt < 4'd4)       mem_addr[hcnt[1:0]*8 +: 8] <= rx_byte;
            else if (hcnt < 4'd8)  cnt_q[hcnt[1:0]*8 +: 8] <= rx_byte;
            else if (hcnt == 4'd8) begin
              fill_q <= rx_byte[0];
              pin_lo <= rx_byte[7:5];
            end else begin
              pin_hi  <= rx_byte[2:0];
              final_q <= rx_byte[7];
            end
            if (hcnt == 4'(HDR_LAST)) begin
              hcnt <= '0;
              st   <= S_DEC;
            end else begin
              hcnt <= hcnt + 4'd1;
            end
          end
          S_DEC: begin
            pin_q <= {pin_hi, pin_lo};
            if (cnt_q == '0) begin
              if (final_q) begin
                start_pulse <= 1'b1;
                st          <= S_DONE;
              end else begin
                st <= S_HDR;
              end
            end else begin
              st <= fill_q ? S_FILL : S_PAY;
            end
          end
          S_PAY, S_FILL: begin
            if (accept) begin
              mem_we   <= 1'b0;
              mem_addr <= mem_addr + 32'd1;
              if (cnt_q == '0) begin
                if (final_q) begin
                  start_pulse <= 1'b1;
                  st          <= S_DONE;
                end else begin
                  st <= S_HDR;
                end
              end
            end else if (!mem_we && cnt_q != '0 && (st == S_FILL || byte_vld)) begin
              mem_we    <= 1'b1;
              mem_wdata <= (st == S_FILL) ? 8'h00 : rx_byte;
              cnt_q     <= cnt_q - 32'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module spi_boot_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_reset,
  input logic        cfg_bypass,
  input logic [63:0] gpio_wait,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic        mem_ready,
  input logic        start_pulse
);
  p_wait_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gpio_wait));

  p_stall_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_ready) |-> (gpio_wait != '0));

  p_write_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_ready && !sw_reset) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));

  p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  p_start_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !mem_we);

  p_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_reset && cfg_bypass) |=> (start_pulse && !mem_we));
endmodule

bind spi_boot_loader spi_boot_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .cfg_bypass(cfg_bypass),
  .gpio_wait(gpio_wait), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready), .start_pulse(start_pulse)
);

// File: tb/spi_boot_loader_test.sv
module spi_boot_loader_test;
  localparam int CLK_P = 10;
  localparam logic [31:0] BASE = 32'h0000_8000;

  logic clk = 1'b0, rst_n = 1'b0, sw_reset = 1'b0, cfg_bypass = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic [63:0] gpio_wait;
  logic mem_we, mem_ready, start_pulse;
  logic [31:0] mem_addr, start_addr;
  logic [7:0] mem_wdata;

  int checks = 0, errors = 0, starts = 0, wait_seen = 0;
  logic [5:0] exp_pin = '0;
  logic expect_start = 1'b0, stall_en = 1'b0;
  logic [31:0] cyc = '0;
  logic [31:0] qa[$];
  logic [7:0]  qd[$];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign mem_ready = !stall_en || (cyc[1:0] == 2'd0);

  spi_boot_loader #(.IMEM_BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .cfg_bypass(cfg_bypass),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .gpio_wait(gpio_wait), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .start_pulse(start_pulse), .start_addr(start_addr));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if ((gpio_wait & ~(64'd1 << exp_pin)) != 0) check(0, "R9 stray wait line", gpio_wait, 64'd1 << exp_pin);
    if (mem_we && !mem_ready) check(gpio_wait[exp_pin], "R8 wait during stall", gpio_wait, 64'd1 << exp_pin);
    if (gpio_wait[exp_pin]) wait_seen++;
    if (mem_we && mem_ready) begin
      if (qa.size() == 0) check(0, "R3 unexpected write", {mem_addr, 24'd0, mem_wdata}, 64'd0);
      else begin
        logic [31:0] ea; logic [7:0] ed;
        ea = qa.pop_front(); ed = qd.pop_front();
        check(mem_addr == ea && mem_wdata == ed, "R3 write addr/data",
              {mem_addr, 24'd0, mem_wdata}, {ea, 24'd0, ed});
      end
    end
    if (start_pulse) begin
      check(expect_start && qa.size() == 0, "R5/R10 start pulse timing", {63'd0, expect_start}, 64'd1);
      check(start_addr == BASE, "R5 start address", start_addr, BASE);
      expect_start = 1'b0;
      starts++;
    end
  end

  task automatic spi_byte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      @(negedge clk); spi_sck = 1'b0; spi_mosi = b[k];
      repeat (3) @(negedge clk);
      spi_sck = 1'b1;
      repeat (4) @(negedge clk);
    end
    spi_sck = 1'b0;
  endtask

  task automatic hold_off();
    repeat (8) @(negedge clk);
    while (gpio_wait[exp_pin]) @(negedge clk);
  endtask

  task automatic send_block(input logic [31:0] a, input logic [31:0] n, input logic [15:0] f, input logic [7:0] seed);
    logic [79:0] h;
    h = {f, n, a};
    for (int i = 0; i < n; i++) begin
      qa.push_back(a + i);
      qd.push_back(f[0] ? 8'h00 : seed + 8'(i * 7));
    end
    for (int i = 0; i < 10; i++) begin
      if (i == 9) begin exp_pin = f[10:5]; wait_seen = 0; end
      spi_byte(h[8*i +: 8]);
      hold_off();
    end
    check(wait_seen > 0, "R8 decode-cycle wait", wait_seen, 1);
    if (!f[0]) for (int i = 0; i < n; i++) begin
      spi_byte(seed + 8'(i * 7));
      hold_off();
    end
    repeat (4) @(negedge clk);
    check(qa.size() == 0, "R4 block fully written", qa.size(), 0);
  endtask

  task automatic pulse_sw(input logic byp);
    @(negedge clk); cfg_bypass = byp; sw_reset = 1'b1;
    @(negedge clk); sw_reset = 1'b0; cfg_bypass = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(gpio_wait == 0 && !mem_we && !start_pulse, "R12 reset state",
          {gpio_wait[61:0], mem_we, start_pulse}, 64'd0);
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);

    // R2 R3: plain payload, wait line 5
    send_block(32'h0000_0100, 4, 16'(5 << 5), 8'hA0);
    // R7: empty non-final block skipped
    send_block(32'h0000_0900, 0, 16'(9 << 5), 8'h00);
    // R3 R8: stalled memory, wait line 63
    stall_en = 1'b1;
    send_block(32'h0000_2000, 5, 16'(63 << 5), 8'h11);
    // R6: zero fill, no payload consumed
    send_block(32'h0000_3000, 6, 16'((2 << 5) | 1), 8'h00);
    // R1: partial byte discarded by chip select
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); spi_mosi = 1'b1; repeat (3) @(negedge clk);
      spi_sck = 1'b1; repeat (4) @(negedge clk); spi_sck = 1'b0;
    end
    repeat (4) @(negedge clk); spi_cs_n = 1'b1;
    repeat (6) @(negedge clk); spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    // R5: final block with stalls
    expect_start = 1'b1;
    send_block(32'h0000_0040, 3, 16'h8000 | 16'(1 << 5), 8'h5C);
    check(starts == 1, "R5 one start after final block", starts, 1);

    // R11: restart, partial header dropped by a second software reset
    pulse_sw(1'b0);
    for (int i = 0; i < 4; i++) begin spi_byte(8'hFF); hold_off(); end
    pulse_sw(1'b0);
    expect_start = 1'b1;
    send_block(32'h0000_0500, 2, 16'h8000 | 16'(7 << 5), 8'h33);
    check(starts == 2, "R11 load after restart", starts, 2);

    // R10: bypass mid-header
    pulse_sw(1'b0);
    for (int i = 0; i < 3; i++) begin spi_byte(8'h77); hold_off(); end
    expect_start = 1'b1;
    pulse_sw(1'b1);
    check(starts == 3, "R10 bypass start", starts, 3);
    for (int i = 0; i < 10; i++) begin spi_byte(8'h01); repeat (4) @(negedge clk); end
    check(!mem_we && starts == 3 && qa.size() == 0, "R10 nothing loaded after bypass",
          {31'd0, mem_we, 32'(starts)}, 64'd3);

    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule